// File: doc/BRIEF.md
# Aligned Fetch Packet Dispatch Masker

This block sits between instruction memory and the dispatch stage of a VLIW-style core. A redirect supplies a word-aligned target. The block requests the eight-word (256-bit) fetch packet that contains the target, at the target with its low five address bits cleared. When the packet returns, every word stored ahead of the target word is masked off and never issues.

The surviving words are split into execute packets. Bit 0 of each word says whether the next stored word belongs to the same execute packet. One execute packet is offered per handshake, as a lane mask plus the words. A redirect can land inside an execute packet. In that case the stored words before the target are dropped even when their parallel bit links them to the target.

When the last valid word of a packet has been taken, the next aligned packet is requested with all eight words valid. A redirect flushes any words that have not yet been dispatched. It also discards the response to any memory request it supersedes.

Top module: `fp_dispatch_masker`

## Requirements
- R1: While reset is asserted, and after its release until the first redirect, `ep_valid_o` and `mem_req_valid_o` stay 0.
- R2: The cycle after a redirect with target T (byte address), `mem_req_valid_o` is 1 and `mem_req_addr_o` is T with bits 4:0 cleared. The request holds its address until it is accepted.
- R3: In the first packet after a redirect, word indices below T[4:2] are never offered, and the first execute packet starts at word T[4:2].
- R4: If the target word follows a word whose bit 0 is 1, the earlier word is still excluded. The execute packet runs from the target word through the first word at or after it whose bit 0 is 0.
- R5: An offered execute packet covers the lowest still-valid word and each following word, ending with the first word whose bit 0 is 0.
- R6: An execute packet whose parallel chain reaches word 7 ends there, even if bit 0 of word 7 is 1.
- R7: Each `ep_valid_o`/`ep_ready_i` handshake removes exactly the offered lanes. While stalled with no redirect, the lanes and words hold steady.
- R8: When the handshake consumes the last valid word, the next cycle requests the address 32 higher. The returned packet is offered with all eight words valid. No request is made while an execute packet is offered.
- R9: A redirect flushes all undispatched words, so `ep_valid_o` is 0 in the next cycle. A packet whose handshake completes in the redirect cycle counts as delivered. The next packet offered comes from the new target.
- R10: A memory response belonging to a request made before the latest redirect is accepted but discarded. Only the response to the new request is dispatched.
- R11: `ep_words_o` carries word i of the packet in bits 32i+31:32i for each lane set in `ep_lanes_o`, and zero in every other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Redirect to a new target this cycle |
| br_target_i | input | 30 | Target byte address bits 31:2 (word aligned) |
| mem_req_valid_o | output | 1 | Fetch request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Aligned fetch packet byte address |
| mem_rsp_valid_i | input | 1 | Fetch packet data valid |
| mem_rsp_ready_o | output | 1 | Block accepts the response |
| mem_rsp_data_i | input | 256 | Eight words, word i in bits 32i+31:32i |
| ep_valid_o | output | 1 | Execute packet offered |
| ep_ready_i | input | 1 | Dispatch takes the packet |
| ep_lanes_o | output | 8 | Lanes of the offered execute packet |
| ep_words_o | output | 256 | Packet words, zero outside the lanes |

## Verification
A redirect and an execute-packet handshake can fall in the same cycle. The redirect must then flush only the words left after the delivered packet, and the next packet must come from the new target. A redirect can also arrive while a fetch response is outstanding, and that response must be thrown away. Directed cases raise the redirect in the very cycle a mid-packet handshake completes, and issue a second redirect while the memory is held slow. Random redirects mixed with random dispatch stalls cover these collisions further. A reference model follows every handshake at the ports and judges each offered lane mask, word vector and fetch address.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned FPD_WORDS  = 8;
  localparam int unsigned FPD_WORD_W = 32;
  localparam int unsigned FPD_ADDR_W = 32;

  typedef struct packed {
    logic req;    // request pending to memory
    logic busy;   // request accepted, response outstanding
    logic stale;  // outstanding response belongs to a superseded target
  } fetch_flags_t;
endpackage

// File: rtl/fpd_fetch_ctl.sv
module fpd_fetch_ctl import fpd_pkg::*; #(
  parameter int unsigned ADDR_W = FPD_ADDR_W,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned OFF_W  = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:2] br_tgt_i,
  input  logic              seq_next_i,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_rsp_ready_o,
  output logic              load_o,
  output logic [IDX_W-1:0]  start_idx_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFF_W;

  fetch_flags_t       fl_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [IDX_W-1:0]   start_q;
  logic               req_fire, rsp_fire, busy_d;

  assign mem_req_valid_o = fl_q.req & ~fl_q.busy;
  assign mem_req_addr_o  = pc_q;
  assign mem_rsp_ready_o = fl_q.busy;
  assign req_fire        = mem_req_valid_o & mem_req_ready_i;
  assign rsp_fire        = fl_q.busy & mem_rsp_valid_i;
  assign busy_d          = (fl_q.busy & ~rsp_fire) | req_fire;
  assign load_o          = rsp_fire & ~fl_q.stale & ~br_valid_i;
  assign start_idx_o     = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q    <= '0;
      pc_q    <= '0;
      start_q <= '0;
    end else begin
      fl_q.busy <= busy_d;
      if (br_valid_i) begin
        fl_q.req   <= 1'b1;
        fl_q.stale <= busy_d;  // anything still in flight is now stale
        pc_q       <= {br_tgt_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        start_q    <= br_tgt_i[OFF_W-1:2];
      end else begin
        if (rsp_fire) begin
          fl_q.stale <= 1'b0;
          if (!fl_q.stale) start_q <= '0;
        end
        if (seq_next_i) begin
          fl_q.req <= 1'b1;
          pc_q     <= pc_q + STEP;
        end else if (req_fire) begin
          fl_q.req <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fpd_entry_mask.sv
module fpd_entry_mask #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0] start_i,
  output logic [WORDS-1:0] mask_o
);
  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    assign mask_o[i] = (IDX_W'(i) >= start_i);
  end
endmodule

// File: rtl/fpd_ep_split.sv
module fpd_ep_split #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORDS-1:0]        mask_i,
  input  logic [WORDS*WORD_W-1:0] words_i,
  output logic [WORDS-1:0]        lanes_o,
  output logic [WORDS*WORD_W-1:0] words_o
);
  logic seen, run;

  // lane joins while the previous lane's parallel bit is set; word 7 closes the chain
  always_comb begin
    lanes_o = '0;
    seen    = 1'b0;
    run     = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      lanes_o[i] = mask_i[i] & (~seen | run);
      run        = lanes_o[i] & words_i[i*WORD_W];
      seen       = seen | mask_i[i];
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign words_o[i*WORD_W +: WORD_W] = lanes_o[i] ? words_i[i*WORD_W +: WORD_W] : '0;
  end
endmodule

// File: rtl/fp_dispatch_masker.sv
module fp_dispatch_masker import fpd_pkg::*; #(
  parameter int unsigned WORDS  = FPD_WORDS,
  parameter int unsigned WORD_W = FPD_WORD_W,
  parameter int unsigned ADDR_W = FPD_ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    br_valid_i,
  input  logic [ADDR_W-1:2]       br_target_i,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [ADDR_W-1:0]       mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  output logic                    mem_rsp_ready_o,
  input  logic [WORDS*WORD_W-1:0] mem_rsp_data_i,
  output logic                    ep_valid_o,
  input  logic                    ep_ready_i,
  output logic [WORDS-1:0]        ep_lanes_o,
  output logic [WORDS*WORD_W-1:0] ep_words_o
);
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned OFF_W = IDX_W + 2;
  localparam int unsigned PKT_W = WORDS * WORD_W;

  logic [PKT_W-1:0] buf_q;
  logic [WORDS-1:0] mask_q, entry_mask, mask_left;
  logic [IDX_W-1:0] start_idx;
  logic             load, ep_fire, seq_next;

  assign ep_valid_o = |mask_q;
  assign ep_fire    = ep_valid_o & ep_ready_i;
  assign mask_left  = mask_q & ~ep_lanes_o;
  assign seq_next   = ep_fire & ~|mask_left;

  fpd_fetch_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fetch (
    .clk_i, .rst_ni, .br_valid_i,
    .br_tgt_i        (br_target_i),
    .seq_next_i      (seq_next),
    .mem_req_ready_i, .mem_rsp_valid_i, .mem_req_valid_o, .mem_req_addr_o, .mem_rsp_ready_o,
    .load_o          (load),
    .start_idx_o     (start_idx)
  );

  fpd_entry_mask #(.WORDS(WORDS), .IDX_W(IDX_W)) u_entry (
    .start_i (start_idx),
    .mask_o  (entry_mask)
  );

  fpd_ep_split #(.WORDS(WORDS), .WORD_W(WORD_W)) u_split (
    .mask_i  (mask_q),
    .words_i (buf_q),
    .lanes_o (ep_lanes_o),
    .words_o (ep_words_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      buf_q  <= '0;
    end else if (br_valid_i) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= entry_mask;
      buf_q  <= mem_rsp_data_i;
    end else if (ep_fire) begin
      mask_q <= mask_left;
    end
  end
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    br_valid_i,
  input logic                    mem_req_valid_o,
  input logic                    mem_req_ready_i,
  input logic [ADDR_W-1:0]       mem_req_addr_o,
  input logic                    ep_valid_o,
  input logic                    ep_ready_i,
  input logic [WORDS-1:0]        ep_lanes_o,
  input logic [WORDS*WORD_W-1:0] ep_words_o
);
  logic [WORDS-1:0] low_lane;
  assign low_lane = ep_lanes_o & (~ep_lanes_o + WORDS'(1));

  a_r5_lanes_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o |-> (ep_lanes_o != '0) && (((ep_lanes_o + low_lane) & ep_lanes_o) == '0));

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o && !ep_ready_i && !br_valid_i |=>
      ep_valid_o && $stable(ep_lanes_o) && $stable(ep_words_o));

  a_r9_branch_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |=> !ep_valid_o);

  a_r8_no_req_while_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !ep_valid_o);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i && !br_valid_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o));
endmodule

bind fp_dispatch_masker fpd_checker #(.WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .br_valid_i, .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o,
  .ep_valid_o, .ep_ready_i, .ep_lanes_o, .ep_words_o
);

// File: tb/fp_dispatch_masker_test.sv
module fp_dispatch_masker_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         br_valid = 1'b0;
  logic [31:2]  br_tgt = '0;
  logic         ep_ready = 1'b0;
  logic         mem_req_ready = 1'b0;
  logic         mem_rsp_valid = 1'b0;
  logic [255:0] mem_rsp_data = '0;
  logic         mem_req_valid_o, mem_rsp_ready_o, ep_valid_o;
  logic [31:0]  mem_req_addr_o;
  logic [7:0]   ep_lanes_o;
  logic [255:0] ep_words_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] dir_par = '0;
  bit slow = 1'b0;

  always #2.5 clk = ~clk;

  fp_dispatch_masker uut (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_target_i(br_tgt),
    .mem_req_valid_o, .mem_req_ready_i(mem_req_ready), .mem_req_addr_o,
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_ready_o, .mem_rsp_data_i(mem_rsp_data),
    .ep_valid_o, .ep_ready_i(ep_ready), .ep_lanes_o, .ep_words_o
  );

  function automatic logic [31:0] dw(logic [31:0] a, int i);
    logic [9:0] h = 10'(a[14:5] * 10'd37 + 10'(i) * 10'd91);
    logic p = (a[31:28] == 4'h1) ? dir_par[i] : (h[3:1] < 3'd5);
    return {a[22:5], 3'(i), h, p};
  endfunction

  function automatic logic [255:0] pkt(logic [31:0] a);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = dw(a, i);
    return r;
  endfunction

  function automatic logic [7:0] ref_lanes(logic [7:0] m, logic [255:0] w);
    int f = -1;
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (m[i] && f < 0) f = i;
    if (f < 0) return '0;
    for (int i = f; i < 8; i++) begin
      r[i] = 1'b1;
      if (!w[i*32]) break;
    end
    return r;
  endfunction

  function automatic logic [255:0] ref_words(logic [7:0] l, logic [255:0] w);
    logic [255:0] r = '0;
    for (int i = 0; i < 8; i++) if (l[i]) r[i*32 +: 32] = w[i*32 +: 32];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder
  logic        m_pend = 1'b0;
  logic [31:0] m_paddr = '0;
  int          m_dly = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 1'b0; mem_rsp_valid <= 1'b0; mem_req_ready <= 1'b0;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready_o) begin
        mem_rsp_valid <= 1'b0; m_pend <= 1'b0;
      end else if (m_pend && !mem_rsp_valid) begin
        if (m_dly == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= pkt(m_paddr);
        end else m_dly <= m_dly - 1;
      end
      if (mem_req_valid_o && mem_req_ready) begin
        m_pend <= 1'b1; m_paddr <= mem_req_addr_o;
        m_dly <= slow ? 6 : int'($urandom % 4);
      end
      mem_req_ready <= slow ? 1'b1 : (($urandom % 4) != 0);
    end
  end

  // reference model, follows port handshakes
  logic         r_req, r_wait, r_drop;
  logic [31:0]  r_fa;
  logic [2:0]   r_start;
  logic [7:0]   r_mask, r_l;
  logic [255:0] r_w;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
    if (!rst_n) begin
      r_req = 0; r_wait = 0; r_drop = 0; r_fa = 0; r_start = 0; r_mask = 0; r_w = 0;
    end else begin
      bit rq_v, rq_f, rs_f, ep_f, wn;
      rq_v = r_req && !r_wait;
      r_l = ref_lanes(r_mask, r_w);
      chk(ep_valid_o == (r_mask != 0), "R7 ep_valid", 256'(ep_valid_o), 256'(r_mask != 0));
      if (ep_valid_o && r_mask != 0) begin
        chk(ep_lanes_o == r_l, "R5 lanes", 256'(ep_lanes_o), 256'(r_l));
        chk(ep_words_o == ref_words(r_l, r_w), "R11 words", ep_words_o, ref_words(r_l, r_w));
      end
      chk(mem_req_valid_o == rq_v, "R8 req_valid", 256'(mem_req_valid_o), 256'(rq_v));
      if (rq_v) chk(mem_req_addr_o == r_fa, "R2 req_addr", 256'(mem_req_addr_o), 256'(r_fa));
      rq_f = rq_v && mem_req_ready;
      rs_f = r_wait && mem_rsp_valid;
      ep_f = (r_mask != 0) && ep_ready;
      wn = (r_wait && !rs_f) || rq_f;
      if (br_valid) begin
        r_drop = wn; r_req = 1; r_fa = {br_tgt[31:5], 5'b0}; r_start = br_tgt[4:2]; r_mask = 0;
      end else begin
        if (rs_f) begin
          if (r_drop) r_drop = 0;
          else begin r_mask = 8'hFF << r_start; r_w = mem_rsp_data; r_start = 0; end
        end
        if (rq_f) r_req = 0;
        if (ep_f) begin
          r_mask = r_mask & ~r_l;
          if (r_mask == 0) begin r_req = 1; r_fa = r_fa + 32; end
        end
      end
      r_wait = wn;
    end
  end

  task automatic redirect(logic [31:0] a);
    @(negedge clk); br_valid = 1'b1; br_tgt = a[31:2];
    @(negedge clk); br_valid = 1'b0;
  endtask

  task automatic wait_ep();
    int t = 0;
    while (!ep_valid_o && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic take();
    ep_ready = 1'b1; @(negedge clk); ep_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ep_valid_o && !mem_req_valid_o, "R1 in reset", 256'({ep_valid_o, mem_req_valid_o}), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ep_valid_o && !mem_req_valid_o, "R1 idle", 256'({ep_valid_o, mem_req_valid_o}), 256'(0));

    // R2 / R3: entry at word 5
    dir_par = 8'h00;
    @(negedge clk); br_valid = 1'b1; br_tgt = 30'(32'h1000_0014 >> 2);
    @(negedge clk); br_valid = 1'b0;
    chk(mem_req_valid_o && mem_req_addr_o == 32'h1000_0000, "R2 aligned addr",
        256'(mem_req_addr_o), 256'(32'h1000_0000));
    wait_ep();
    chk(ep_lanes_o == 8'h20, "R3 entry lane", 256'(ep_lanes_o), 256'(8'h20));
    chk(ep_words_o[5*32 +: 32] == dw(32'h1000_0000, 5), "R3 entry word",
        256'(ep_words_o[5*32 +: 32]), 256'(dw(32'h1000_0000, 5)));
    take();
    chk(ep_lanes_o == 8'h40, "R5 next lane", 256'(ep_lanes_o), 256'(8'h40));
    take(); take();
    chk(mem_req_valid_o && mem_req_addr_o == 32'h1000_0020, "R8 sequential addr",
        256'(mem_req_addr_o), 256'(32'h1000_0020));
    wait_ep();
    chk(ep_lanes_o == 8'h01, "R8 full mask", 256'(ep_lanes_o), 256'(8'h01));

    // R4: entry inside an execute packet spanning words 1..5
    dir_par = 8'b0001_1110;
    redirect(32'h1000_010C);
    wait_ep();
    chk(ep_lanes_o == 8'h38, "R4 mid packet entry", 256'(ep_lanes_o), 256'(8'h38));
    repeat (3) @(negedge clk);
    chk(ep_valid_o && ep_lanes_o == 8'h38, "R7 stall hold", 256'(ep_lanes_o), 256'(8'h38));
    take();
    chk(ep_lanes_o == 8'h40, "R7 one packet per handshake", 256'(ep_lanes_o), 256'(8'h40));

    // R6: chain reaching word 7
    dir_par = 8'b1100_0000;
    redirect(32'h1000_0218);
    wait_ep();
    chk(ep_lanes_o == 8'hC0, "R6 boundary end", 256'(ep_lanes_o), 256'(8'hC0));
    take();
    chk(mem_req_valid_o && mem_req_addr_o == 32'h1000_0220, "R6 next packet",
        256'(mem_req_addr_o), 256'(32'h1000_0220));

    // R9: redirect in the same cycle as a handshake
    dir_par = 8'h00;
    redirect(32'h1000_0300);
    wait_ep(); take();
    chk(ep_lanes_o == 8'h02, "R9 partial state", 256'(ep_lanes_o), 256'(8'h02));
    br_valid = 1'b1; br_tgt = 30'(32'h1000_0408 >> 2); ep_ready = 1'b1;
    @(negedge clk); br_valid = 1'b0; ep_ready = 1'b0;
    chk(!ep_valid_o, "R9 flushed", 256'(ep_valid_o), 256'(0));
    wait_ep();
    chk(ep_lanes_o == 8'h04 && ep_words_o[2*32 +: 32] == dw(32'h1000_0400, 2), "R9 new target",
        256'(ep_words_o[2*32 +: 32]), 256'(dw(32'h1000_0400, 2)));
    take();

    // R10: second redirect while the first response is in flight
    slow = 1'b1;
    repeat (2) @(negedge clk);
    redirect(32'h1000_0500);
    @(negedge clk);
    redirect(32'h1000_0604);
    wait_ep();
    chk(ep_lanes_o == 8'h02 && ep_words_o[32 +: 32] == dw(32'h1000_0600, 1), "R10 stale dropped",
        256'(ep_words_o[32 +: 32]), 256'(dw(32'h1000_0600, 1)));
    slow = 1'b0;

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      ep_ready = ($urandom % 3) != 0;
      br_valid = ($urandom % 25) == 0;
      br_tgt   = {4'h2, 26'($urandom)};
    end
    @(negedge clk); br_valid = 1'b0; ep_ready = 1'b1;
    repeat (20) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule